// File: doc/BRIEF.md
# Iterated SHA-512 Stretching Engine

This block stretches a key by running SHA-512 over and over for a configured number of passes. A pass hashes one fixed-length message. The message is the 32-bit pass index followed by the digest that the previous pass produced. The first pass takes the digest supplied with the start pulse. When the last pass completes, the engine returns the final 512-bit digest. Typical key-derivation settings use about 100,000 passes.

A single rolled compression datapath does all the work. It has one round unit and one message-schedule unit that keeps a sliding window of 16 words. A small controller steps this datapath through 80 rounds and then one feed-forward cycle, so every pass costs 81 cycles. Software gives a start pulse together with the seed digest and the pass count. It then waits for the done pulse and reads the result, which stays on the output until the next accepted start.

Top module: `sha512_stretch`

## Requirements
- R1: After reset, busy and done are both low.
- R2: A start pulse seen while the engine is idle is accepted. From the next cycle, busy stays high up to and including the cycle in which done is high, and it is low in the cycle after that.
- R3: For a pass count N, done is high for exactly one cycle. That cycle comes 81·N+1 cycles after the cycle in which start was sampled.
- R4: Pass n hashes a 68-byte message. The first four bytes are the bytes of n, least significant byte first. The remaining 64 bytes are the previous digest, starting from its most significant byte (bits 511:504). Standard SHA-512 padding completes a single 1024-bit block: a 0x80 byte, zero bytes, and a 128-bit big-endian length of 544.
- R5: Each pass is one standard SHA-512 compression. It starts from the standard initial hash words and adds them back in after round 79. The compression yields the standard SHA-512 digest of "abc".
- R6: The result digest stays unchanged from the done cycle until the next accepted start.
- R7: A pass count of zero raises done in the cycle after start, and the digest output then equals the input digest.
- R8: A start pulse that arrives while busy is high is ignored. The pass count, seed and result of the running job do not change.
- R9: Pass indices run from 0 up to N−1, increasing by one each pass, and each pass takes its digest from the pass before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a job |
| inDigest | input | 512 | Seed digest, sampled with an accepted start |
| iterCount | input | CNT_W | Number of passes, sampled with an accepted start |
| busy | output | 1 | Job in progress, through the done cycle |
| done | output | 1 | One-cycle pulse when the result is ready |
| digest | output | 512 | Result digest |

## Verification
The assertions take start to be a clean synchronous level. They also assume that iterCount and inDigest only matter in the cycle in which an idle engine samples start. The bench drives and samples inputs on the falling edge. It raises start for one cycle at a time and raises it while busy only on purpose, to exercise R8. It keeps pass counts small (zero to three) so that each job can be compared in full with a bench-side SHA-512 model. That model is itself first checked against the known digest of "abc".

// File: rtl/sha_stretch_pkg.sv
package sha_stretch_pkg;
  localparam int ROUNDS = 80;
  localparam int RND_W = $clog2(ROUNDS);
  localparam int IDX_W = 32;
  localparam int MSG_BITS = 544;

  typedef struct packed {
    logic              load;
    logic              step;
    logic              fold;
    logic              reload;
    logic [RND_W-1:0]  rnd;
    logic [IDX_W-1:0]  idx;
  } strobe_t;

  function automatic logic [63:0] rotr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [63:0] bigSig0(input logic [63:0] x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic logic [63:0] bigSig1(input logic [63:0] x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic logic [63:0] smallSig0(input logic [63:0] x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic logic [63:0] smallSig1(input logic [63:0] x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  function automatic logic [63:0] ivWord(input int i);
    case (i)
      0: return 64'h6a09e667f3bcc908;
      1: return 64'hbb67ae8584caa73b;
      2: return 64'h3c6ef372fe94f82b;
      3: return 64'ha54ff53a5f1d36f1;
      4: return 64'h510e527fade682d1;
      5: return 64'h9b05688c2b3e6c1f;
      6: return 64'h1f83d9abfb41bd6b;
      default: return 64'h5be0cd19137e2179;
    endcase
  endfunction

  function automatic logic [63:0] kLow(input logic [5:0] t);
    case (t)
      6'd0:  return 64'h428a2f98d728ae22;  6'd1:  return 64'h7137449123ef65cd;
      6'd2:  return 64'hb5c0fbcfec4d3b2f;  6'd3:  return 64'he9b5dba58189dbbc;
      6'd4:  return 64'h3956c25bf348b538;  6'd5:  return 64'h59f111f1b605d019;
      6'd6:  return 64'h923f82a4af194f9b;  6'd7:  return 64'hab1c5ed5da6d8118;
      6'd8:  return 64'hd807aa98a3030242;  6'd9:  return 64'h12835b0145706fbe;
      6'd10: return 64'h243185be4ee4b28c;  6'd11: return 64'h550c7dc3d5ffb4e2;
      6'd12: return 64'h72be5d74f27b896f;  6'd13: return 64'h80deb1fe3b1696b1;
      6'd14: return 64'h9bdc06a725c71235;  6'd15: return 64'hc19bf174cf692694;
      6'd16: return 64'he49b69c19ef14ad2;  6'd17: return 64'hefbe4786384f25e3;
      6'd18: return 64'h0fc19dc68b8cd5b5;  6'd19: return 64'h240ca1cc77ac9c65;
      6'd20: return 64'h2de92c6f592b0275;  6'd21: return 64'h4a7484aa6ea6e483;
      6'd22: return 64'h5cb0a9dcbd41fbd4;  6'd23: return 64'h76f988da831153b5;
      6'd24: return 64'h983e5152ee66dfab;  6'd25: return 64'ha831c66d2db43210;
      6'd26: return 64'hb00327c898fb213f;  6'd27: return 64'hbf597fc7beef0ee4;
      6'd28: return 64'hc6e00bf33da88fc2;  6'd29: return 64'hd5a79147930aa725;
      6'd30: return 64'h06ca6351e003826f;  6'd31: return 64'h142929670a0e6e70;
      6'd32: return 64'h27b70a8546d22ffc;  6'd33: return 64'h2e1b21385c26c926;
      6'd34: return 64'h4d2c6dfc5ac42aed;  6'd35: return 64'h53380d139d95b3df;
      6'd36: return 64'h650a73548baf63de;  6'd37: return 64'h766a0abb3c77b2a8;
      6'd38: return 64'h81c2c92e47edaee6;  6'd39: return 64'h92722c851482353b;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [63:0] kHigh(input logic [5:0] t);
    case (t)
      6'd0:  return 64'ha2bfe8a14cf10364;  6'd1:  return 64'ha81a664bbc423001;
      6'd2:  return 64'hc24b8b70d0f89791;  6'd3:  return 64'hc76c51a30654be30;
      6'd4:  return 64'hd192e819d6ef5218;  6'd5:  return 64'hd69906245565a910;
      6'd6:  return 64'hf40e35855771202a;  6'd7:  return 64'h106aa07032bbd1b8;
      6'd8:  return 64'h19a4c116b8d2d0c8;  6'd9:  return 64'h1e376c085141ab53;
      6'd10: return 64'h2748774cdf8eeb99;  6'd11: return 64'h34b0bcb5e19b48a8;
      6'd12: return 64'h391c0cb3c5c95a63;  6'd13: return 64'h4ed8aa4ae3418acb;
      6'd14: return 64'h5b9cca4f7763e373;  6'd15: return 64'h682e6ff3d6b2b8a3;
      6'd16: return 64'h748f82ee5defb2fc;  6'd17: return 64'h78a5636f43172f60;
      6'd18: return 64'h84c87814a1f0ab72;  6'd19: return 64'h8cc702081a6439ec;
      6'd20: return 64'h90befffa23631e28;  6'd21: return 64'ha4506cebde82bde9;
      6'd22: return 64'hbef9a3f7b2c67915;  6'd23: return 64'hc67178f2e372532b;
      6'd24: return 64'hca273eceea26619c;  6'd25: return 64'hd186b8c721c0c207;
      6'd26: return 64'heada7dd6cde0eb1e;  6'd27: return 64'hf57d4f7fee6ed178;
      6'd28: return 64'h06f067aa72176fba;  6'd29: return 64'h0a637dc5a2c898a6;
      6'd30: return 64'h113f9804bef90dae;  6'd31: return 64'h1b710b35131c471b;
      6'd32: return 64'h28db77f523047d84;  6'd33: return 64'h32caab7b40c72493;
      6'd34: return 64'h3c9ebe0a15c9bebc;  6'd35: return 64'h431d67c49c100d4c;
      6'd36: return 64'h4cc5d4becb3e42b6;  6'd37: return 64'h597f299cfc657e2a;
      6'd38: return 64'h5fcb6fab3ad6faec;  6'd39: return 64'h6c44198c4a475817;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [63:0] kConst(input logic [RND_W-1:0] t);
    if (t < RND_W'(40)) return kLow(6'(t));
    else return kHigh(6'(t - RND_W'(40)));
  endfunction
endpackage

// File: rtl/sha_stretch_dpath.sv
module sha_stretch_dpath
  import sha_stretch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      ctl,
  input  logic [511:0] inDigest,
  output logic [511:0] digest
);
  localparam int WORDS = 8;
  localparam int WIN = 16;
  localparam int PAD_ZEROS = 1024 - MSG_BITS - 1 - 128;

  logic [63:0]   wv [WORDS];
  logic [63:0]   win [WIN];
  logic [511:0]  digestReg;
  logic [511:0]  sumDigest;
  logic [511:0]  srcDigest;
  logic [1023:0] blk;
  logic [63:0]   t1, t2, wNext;

  // feed-forward adders, one per state word
  for (genvar i = 0; i < WORDS; i++) begin : g_ff
    assign sumDigest[511-64*i -: 64] = ivWord(i) + wv[i];
  end

  // message block for the next pass: index LE, prior digest, pad, length
  always_comb begin
    srcDigest = ctl.load ? inDigest : sumDigest;
    blk = {ctl.idx[7:0], ctl.idx[15:8], ctl.idx[23:16], ctl.idx[31:24],
           srcDigest, 1'b1, {PAD_ZEROS{1'b0}}, 128'(MSG_BITS)};
  end

  always_comb begin
    t1 = wv[7] + bigSig1(wv[4]) + ((wv[4] & wv[5]) ^ (~wv[4] & wv[6]))
         + kConst(ctl.rnd) + win[0];
    t2 = bigSig0(wv[0]) + ((wv[0] & wv[1]) ^ (wv[0] & wv[2]) ^ (wv[1] & wv[2]));
    wNext = smallSig1(win[14]) + win[9] + smallSig0(win[1]) + win[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      digestReg <= '0;
      for (int i = 0; i < WORDS; i++) wv[i] <= '0;
      for (int i = 0; i < WIN; i++) win[i] <= '0;
    end else begin
      if (ctl.load) digestReg <= inDigest;
      else if (ctl.fold) digestReg <= sumDigest;

      if (ctl.load || ctl.reload) begin
        for (int i = 0; i < WORDS; i++) wv[i] <= ivWord(i);
        for (int i = 0; i < WIN; i++) win[i] <= blk[1023-64*i -: 64];
      end else if (ctl.step) begin
        wv[0] <= t1 + t2;
        wv[1] <= wv[0];
        wv[2] <= wv[1];
        wv[3] <= wv[2];
        wv[4] <= wv[3] + t1;
        wv[5] <= wv[4];
        wv[6] <= wv[5];
        wv[7] <= wv[6];
        for (int i = 0; i < WIN - 1; i++) win[i] <= win[i+1];
        win[WIN-1] <= wNext;
      end
    end
  end

  assign digest = digestReg;

  // R6
  hold_during_round_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.load) |=> $stable(digest));
endmodule

// File: rtl/sha_stretch_ctrl.sv
module sha_stretch_ctrl
  import sha_stretch_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] iterCount,
  output strobe_t          ctl,
  output logic             busy,
  output logic             done
);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ROUND, S_ADD, S_DONE} state_t;

  state_t           state;
  logic [RND_W-1:0] rnd;
  logic [CNT_W-1:0] idx, cnt;
  logic             accept, lastPass;

  assign accept   = start && (state == S_IDLE);
  assign lastPass = (idx == cnt - 1'b1);

  always_comb begin
    ctl.load   = accept;
    ctl.step   = (state == S_ROUND);
    ctl.fold   = (state == S_ADD);
    ctl.reload = (state == S_ADD) && !lastPass;
    ctl.rnd    = rnd;
    ctl.idx    = accept ? '0 : IDX_W'(idx + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      rnd   <= '0;
      idx   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cnt   <= iterCount;
          idx   <= '0;
          rnd   <= '0;
          state <= (iterCount == '0) ? S_DONE : S_ROUND;
        end
        S_ROUND: begin
          rnd <= rnd + 1'b1;
          if (rnd == LAST_RND) state <= S_ADD;
        end
        S_ADD: begin
          rnd <= '0;
          if (lastPass) state <= S_DONE;
          else begin
            idx   <= idx + 1'b1;
            state <= S_ROUND;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(cnt));
  // R3
  round_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ROUND && rnd == LAST_RND) |=> (state == S_ADD));
endmodule

// File: rtl/sha512_stretch.sv
module sha512_stretch
  import sha_stretch_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [511:0]     inDigest,
  input  logic [CNT_W-1:0] iterCount,
  output logic             busy,
  output logic             done,
  output logic [511:0]     digest
);
  strobe_t ctl;

  sha_stretch_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .iterCount(iterCount),
    .ctl(ctl), .busy(busy), .done(done)
  );

  sha_stretch_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inDigest(inDigest), .digest(digest)
  );

  // R7
  zero_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && iterCount == '0) |=> (done && digest == $past(inDigest)));
endmodule

// File: tb/sim_sha512_stretch.sv
module sim_sha512_stretch;
  import sha_stretch_pkg::kConst;

  localparam int CLK_NS = 10;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [511:0]     inDigest = '0;
  logic [CNT_W-1:0] iterCount = '0;
  logic             busy, done;
  logic [511:0]     digest;

  int checks = 0;
  int fails = 0;

  sha512_stretch #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .inDigest(inDigest),
    .iterCount(iterCount), .busy(busy), .done(done), .digest(digest)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [511:0] compress(input logic [1023:0] b);
    logic [63:0] w [80];
    logic [63:0] h [8];
    logic [63:0] v [8];
    logic [63:0] s1, s0, ch, mj, x1, x2;
    logic [511:0] r;
    h[0] = 64'h6a09e667f3bcc908; h[1] = 64'hbb67ae8584caa73b;
    h[2] = 64'h3c6ef372fe94f82b; h[3] = 64'ha54ff53a5f1d36f1;
    h[4] = 64'h510e527fade682d1; h[5] = 64'h9b05688c2b3e6c1f;
    h[6] = 64'h1f83d9abfb41bd6b; h[7] = 64'h5be0cd19137e2179;
    for (int t = 0; t < 16; t++) w[t] = b[1023-64*t -: 64];
    for (int t = 16; t < 80; t++)
      w[t] = (rr(w[t-2],19) ^ rr(w[t-2],61) ^ (w[t-2] >> 6)) + w[t-7]
           + (rr(w[t-15],1) ^ rr(w[t-15],8) ^ (w[t-15] >> 7)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = h[i];
    for (int t = 0; t < 80; t++) begin
      s1 = rr(v[4],14) ^ rr(v[4],18) ^ rr(v[4],41);
      ch = (v[4] & v[5]) ^ (~v[4] & v[6]);
      x1 = v[7] + s1 + ch + kConst(7'(t)) + w[t];
      s0 = rr(v[0],28) ^ rr(v[0],34) ^ rr(v[0],39);
      mj = (v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]);
      x2 = s0 + mj;
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + x1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = x1 + x2;
    end
    for (int i = 0; i < 8; i++) r[511-64*i -: 64] = h[i] + v[i];
    return r;
  endfunction

  function automatic logic [511:0] stretch(input int n, input logic [511:0] seed);
    logic [511:0] d;
    logic [31:0] k;
    d = seed;
    for (int p = 0; p < n; p++) begin
      k = 32'(p);
      d = compress({k[7:0], k[15:8], k[23:16], k[31:24], d, 1'b1, 351'b0, 128'd544});
    end
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] got, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic runCase(input int n, input logic [511:0] seed, input bit disturb,
                         input string req);
    logic [511:0] exp;
    int k;
    bit seen, busyOk;
    exp = stretch(n, seed);
    @(negedge clk);
    start = 1'b1; iterCount = CNT_W'(n); inDigest = seed;
    k = 0; seen = 0; busyOk = 1;
    while (!seen && k < 81*n + 10) begin
      @(negedge clk);
      k++;
      if (k == 1) start = 1'b0;
      if (disturb && k == 3) begin
        start = 1'b1; iterCount = CNT_W'(n + 5); inDigest = ~seed;
      end
      if (disturb && k == 4) start = 1'b0;
      if (!busy) busyOk = 0;
      if (done) seen = 1;
    end
    // R3 done timing, R2 busy window
    check(seen && k == 81*n + 1, "R3", "done cycle", 512'(k), 512'(81*n + 1));
    check(busyOk, "R2", "busy through done", 512'(busyOk), 512'(1));
    check(digest == exp, req, "digest", digest, exp);
    @(negedge clk);
    check(!busy && !done, "R2", "idle after done", {busy, done}, 512'(0));
    repeat (3) @(negedge clk);
    // R6 result held
    check(digest == exp, "R6", "held digest", digest, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R5 known answer for the model that shares the round constants
    check(compress({24'h616263, 8'h80, 864'b0, 128'd24}) ==
          512'hddaf35a193617abacc417349ae20413112e6fa4e89a97ea20a9eeee64b55d39a2192992a274fc1a836ba3c23a3feebbd454d4423643ce80e2a9ac94fa54ca49f,
          "R5", "abc digest", compress({24'h616263, 8'h80, 864'b0, 128'd24}), '0);
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done, "R1", "reset outputs", {busy, done}, 512'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1", "after reset release", {busy, done}, 512'(0));

    runCase(0, {16{32'hdeadbeef}}, 0, "R7");
    runCase(0, '0, 0, "R7");
    runCase(1, '0, 0, "R4");
    runCase(1, '1, 0, "R5");
    runCase(1, {64{8'h5a}}, 0, "R4");
    runCase(2, {8{64'h0123456789abcdef}}, 0, "R9");
    runCase(3, {16{32'hc0ffee01}}, 0, "R9");
    runCase(2, {16{32'h13579bdf}}, 1, "R8");
    runCase(1, {8{64'hfedcba9876543210}}, 1, "R8");

    summary();
    $finish;
  end
endmodule